// File: doc/BRIEF.md
# UART FIFO Status and DMA-Ready Logic

This block is the buffering and status core of one channel of a 16550-style UART. It holds a transmit queue and a receive queue, each 32 bytes deep by default, and it can fall back to a single holding byte per direction when queueing is turned off. Bytes enter and leave through plain push and pop strobes. On the receive side, a serial receiver pushes each byte together with its parity, framing and break flags. On the transmit side, a shift register pops bytes as it needs them. Serial shifting, baud generation and the host bus are outside the block.

From the queue levels the block builds the line status bits, two active-low DMA ready outputs and three raw interrupt requests. The DMA outputs follow one of two rules. In per-character mode they signal "one byte waiting" or "transmit side empty". In block mode they compare each level against a programmable trigger. An error summary flag stays set while any byte with an error is still held in the receive queue. When every interrupt enable is zero, software runs the channel by polling the status bits.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty. `lsr_o` is 0x60 while `tx_busy_i` is low, `txrdy_no` is 0, `rxrdy_no` is 1, and all interrupt outputs are 0.
- R2: With `fifo_en_i`=1 each queue holds up to 32 bytes and returns them in push order. With `fifo_en_i`=0 each direction holds one byte, and a push into an occupied holding byte is refused. The current occupancy appears on `tx_level_o` and `rx_level_o`.
- R3: A receive push that is refused sets `lsr_o[1]` (overrun). The flag stays set until a receive clear. A refused transmit push is dropped silently.
- R4: A successful pop puts that byte on `rx_data_o` or `tx_data_o` one clock later. A pop on an empty queue leaves the output and the level unchanged. `rx_peek_o` and `tx_peek_o` show the head byte while the queue is non-empty.
- R5: The `rx_clr_i` and `tx_clr_i` strobes empty their queue on the next edge. `rx_clr_i` also clears the overrun and error flags. A clear wins over a push or pop in the same cycle. Any change of `fifo_en_i` clears both queues.
- R6: `lsr_o[0]` is 1 while the receive queue is non-empty. `lsr_o[5]` is 1 while the transmit queue is empty. `lsr_o[6]` is 1 while the transmit queue is empty and `tx_busy_i` is 0.
- R7: The receive error input is bit0 parity, bit1 framing, bit2 break. `lsr_o[4:2]` shows these three bits for the head byte, and is 0 when the queue is empty. `lsr_o[7]` is 1 while any held byte has a non-zero error field. `rx_pop_err_o` gives the error field of the byte last popped.
- R8: Per-character mode applies when `fifo_en_i`=0 or `dma_mode_i`=0. In this mode `rxrdy_no` is low while at least one byte is received, and `txrdy_no` is low while the transmit side is empty.
- R9: Block mode applies when `fifo_en_i`=1 and `dma_mode_i`=1. `rxrdy_no` is low while the receive level is at least the trigger selected by `rx_trig_sel_i` 0/1/2/3 = 1/8/16/28. `txrdy_no` is low while the transmit level is below the trigger selected by `tx_trig_sel_i` 0/1/2/3 = 16/8/4/1.
- R10: `rx_irq_o` = `irq_en_i[0]` and the receive request. `tx_irq_o` = `irq_en_i[1]` and the transmit request. `ls_irq_o` = `irq_en_i[2]` and (overrun or any head error bit). With `irq_en_i`=0 no interrupt output is driven.
- R11: A push and a pop in the same cycle both take effect, so the level stays unchanged. This holds even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: 32-byte queues, 0: single holding bytes |
| dma_mode_i | input | 1 | 1: block mode for ready outputs |
| rx_trig_sel_i | input | 2 | Receive trigger select |
| tx_trig_sel_i | input | 2 | Transmit trigger select |
| rx_clr_i | input | 1 | Receive queue clear strobe |
| tx_clr_i | input | 1 | Transmit queue clear strobe |
| irq_en_i | input | 3 | Interrupt enables: rx, tx, line status |
| tx_push_i | input | 1 | Transmit byte write |
| tx_data_i | input | 8 | Transmit byte in |
| tx_pop_i | input | 1 | Shift register takes a byte |
| tx_busy_i | input | 1 | Shift register still sending |
| tx_data_o | output | 8 | Last byte popped from transmit queue |
| tx_peek_o | output | 8 | Transmit head byte |
| rx_push_i | input | 1 | Receiver delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 3 | Error flags of received byte |
| rx_pop_i | input | 1 | Host reads a byte |
| rx_data_o | output | 8 | Last byte popped from receive queue |
| rx_pop_err_o | output | 3 | Error flags of last popped byte |
| rx_peek_o | output | 8 | Receive head byte |
| tx_level_o | output | 6 | Transmit occupancy |
| rx_level_o | output | 6 | Receive occupancy |
| lsr_o | output | 8 | Line status bits |
| txrdy_no | output | 1 | Transmit DMA ready, active low |
| rxrdy_no | output | 1 | Receive DMA ready, active low |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| ls_irq_o | output | 1 | Line status interrupt request |

## Verification
Push and pop on one queue can land in the same cycle, and so can a clear strobe and a push. The full-queue case matters most, because there the pop must make room for the push, and the overrun flag must stay clear. Directed sequences fill the receive queue to 32 and then push and pop together. Constrained random traffic with biased push and pop rates creates the same collisions at every level, mixed with clear strobes. The bench's queue model decides which event wins, using the rules in R5 and R11, and it judges the result by the levels, the popped bytes, and the overrun and error bits seen the following cycle.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic push_ok;
    logic pop_ok;
    logic drop;
  } fifo_ev_t;

  function automatic int unsigned rx_trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 4;
    endcase
  endfunction

  function automatic int unsigned tx_trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             single_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output fifo_ev_t         ev_o
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q, cap;
  logic [W-1:0]     rdata_q;
  logic             pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign cap     = single_i ? CNT_W'(1) : CNT_W'(DEPTH);
  assign pop_ok  = pop_i & ~clr_i & (count_q != '0);
  // a same-cycle pop frees the slot the push needs
  assign push_ok = push_i & ~clr_i & ((count_q < cap) | pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      rdata_q <= '0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= inc(wptr_q);
      if (pop_ok) begin
        rptr_q  <= inc(rptr_q);
        rdata_q <= mem_q[rptr_q];
      end
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  assign rdata_o      = rdata_q;
  assign head_o       = mem_q[rptr_q];
  assign count_o      = count_q;
  assign ev_o.push_ok = push_ok;
  assign ev_o.pop_ok  = pop_ok;
  assign ev_o.drop    = push_i & ~clr_i & ~push_ok;

  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_single_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && $stable(single_i) && !clr_i && count_q <= CNT_W'(1)) |=> count_q <= CNT_W'(1));
  p_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_q == '0) |=> $stable(rdata_o));
  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_q == '0);
  p_pushpop_level_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !clr_i && count_q != '0) |=> $stable(count_q));

endmodule

// File: rtl/ufc_rx_status.sv
module ufc_rx_status
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  fifo_ev_t         ev_i,
  input  logic             push_err_i,
  input  logic [2:0]       head_err_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             overrun_o,
  output logic             err_held_o,
  output logic [2:0]       head_err_o
);

  logic [CNT_W-1:0] err_cnt_q;
  logic             overrun_q;
  logic             err_in, err_out;

  assign err_in  = ev_i.push_ok & push_err_i;
  assign err_out = ev_i.pop_ok & (|head_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
      overrun_q <= 1'b0;
    end else if (clr_i) begin
      err_cnt_q <= '0;
      overrun_q <= 1'b0;
    end else begin
      err_cnt_q <= err_cnt_q + CNT_W'(err_in) - CNT_W'(err_out);
      if (ev_i.drop) overrun_q <= 1'b1;
    end
  end

  assign overrun_o  = overrun_q;
  assign err_held_o = (err_cnt_q != '0);
  assign head_err_o = (count_i != '0) ? head_err_i : 3'b000;

  p_err_within_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_q <= count_i);
  p_overrun_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_q && !clr_i) |=> overrun_q);

endmodule

// File: rtl/ufc_ready.sv
module ufc_ready
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             block_i,
  input  logic [1:0]       rx_sel_i,
  input  logic [1:0]       tx_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  output logic             rx_req_o,
  output logic             tx_req_o
);

  logic [CNT_W-1:0] rx_trig, tx_trig;

  assign rx_trig = CNT_W'(rx_trig_level(rx_sel_i, DEPTH));
  assign tx_trig = CNT_W'(tx_trig_level(tx_sel_i, DEPTH));

  always_comb begin
    if (block_i) begin
      rx_req_o = (rx_count_i >= rx_trig);
      tx_req_o = (tx_count_i < tx_trig);
    end else begin
      rx_req_o = (rx_count_i != '0);
      tx_req_o = (tx_count_i == '0);
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             dma_mode_i,
  input  logic [1:0]       rx_trig_sel_i,
  input  logic [1:0]       tx_trig_sel_i,
  input  logic             rx_clr_i,
  input  logic             tx_clr_i,
  input  logic [2:0]       irq_en_i,
  input  logic             tx_push_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_pop_i,
  input  logic             tx_busy_i,
  output logic [7:0]       tx_data_o,
  output logic [7:0]       tx_peek_o,
  input  logic             rx_push_i,
  input  logic [7:0]       rx_data_i,
  input  logic [2:0]       rx_err_i,
  input  logic             rx_pop_i,
  output logic [7:0]       rx_data_o,
  output logic [2:0]       rx_pop_err_o,
  output logic [7:0]       rx_peek_o,
  output logic [CNT_W-1:0] tx_level_o,
  output logic [CNT_W-1:0] rx_level_o,
  output logic [7:0]       lsr_o,
  output logic             txrdy_no,
  output logic             rxrdy_no,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             ls_irq_o
);

  logic             en_q, en_chg, rx_clr, tx_clr;
  fifo_ev_t         tx_ev, rx_ev;
  logic [10:0]      rx_rdata, rx_head;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             overrun, err_held, rx_req, tx_req;
  logic [2:0]       head_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= fifo_en_i;
  end

  assign en_chg = en_q ^ fifo_en_i;
  assign rx_clr = rx_clr_i | en_chg;
  assign tx_clr = tx_clr_i | en_chg;

  ufc_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i    (tx_clr),
    .single_i (~fifo_en_i),
    .push_i   (tx_push_i),
    .wdata_i  (tx_data_i),
    .pop_i    (tx_pop_i),
    .rdata_o  (tx_data_o),
    .head_o   (tx_peek_o),
    .count_o  (tx_cnt),
    .ev_o     (tx_ev)
  );

  ufc_fifo #(.DEPTH(DEPTH), .W(11)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i    (rx_clr),
    .single_i (~fifo_en_i),
    .push_i   (rx_push_i),
    .wdata_i  ({rx_err_i, rx_data_i}),
    .pop_i    (rx_pop_i),
    .rdata_o  (rx_rdata),
    .head_o   (rx_head),
    .count_o  (rx_cnt),
    .ev_o     (rx_ev)
  );

  ufc_rx_status #(.DEPTH(DEPTH)) u_rx_status (
    .clk_i, .rst_ni,
    .clr_i      (rx_clr),
    .ev_i       (rx_ev),
    .push_err_i (|rx_err_i),
    .head_err_i (rx_head[10:8]),
    .count_i    (rx_cnt),
    .overrun_o  (overrun),
    .err_held_o (err_held),
    .head_err_o (head_err)
  );

  ufc_ready #(.DEPTH(DEPTH)) u_ready (
    .block_i    (fifo_en_i & dma_mode_i),
    .rx_sel_i   (rx_trig_sel_i),
    .tx_sel_i   (tx_trig_sel_i),
    .rx_count_i (rx_cnt),
    .tx_count_i (tx_cnt),
    .rx_req_o   (rx_req),
    .tx_req_o   (tx_req)
  );

  assign rx_data_o    = rx_rdata[7:0];
  assign rx_pop_err_o = rx_rdata[10:8];
  assign rx_peek_o    = rx_head[7:0];
  assign tx_level_o   = tx_cnt;
  assign rx_level_o   = rx_cnt;

  assign lsr_o = {err_held,
                  (tx_cnt == '0) & ~tx_busy_i,
                  (tx_cnt == '0),
                  head_err,
                  overrun,
                  (rx_cnt != '0)};

  assign rxrdy_no = ~rx_req;
  assign txrdy_no = ~tx_req;
  assign rx_irq_o = irq_en_i[0] & rx_req;
  assign tx_irq_o = irq_en_i[1] & tx_req;
  assign ls_irq_o = irq_en_i[2] & (overrun | (|head_err));

  p_idle_implies_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_o[6] |-> lsr_o[5]);
  p_char_mode_rx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fifo_en_i && dma_mode_i) && lsr_o[0]) |-> !rxrdy_no);
  p_tx_drop_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ev.drop |-> (!tx_ev.push_ok && tx_level_o != '0));
  p_tx_pop_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ev.pop_ok |=> tx_data_o == $past(tx_peek_o));
  p_polled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 3'b000) |-> !(tx_irq_o || rx_irq_o || ls_irq_o));

endmodule

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       fifo_en_i = 0, dma_mode_i = 0, rx_clr_i = 0, tx_clr_i = 0;
  logic [1:0] rx_trig_sel_i = 0, tx_trig_sel_i = 0;
  logic [2:0] irq_en_i = 0, rx_err_i = 0;
  logic       tx_push_i = 0, tx_pop_i = 0, tx_busy_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic [7:0] tx_data_i = 0, rx_data_i = 0;
  logic [7:0] tx_data_o, tx_peek_o, rx_data_o, rx_peek_o, lsr_o;
  logic [2:0] rx_pop_err_o;
  logic [5:0] tx_level_o, rx_level_o;
  logic       txrdy_no, rxrdy_no, tx_irq_o, rx_irq_o, ls_irq_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  uart_fifo_ctrl u_uart_fifo_ctrl (.*);

  int total = 0, fails = 0;
  bit done = 0;

  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  logic [10:0] rx_last = 0;
  logic [7:0]  tx_last = 0;
  bit          ovr = 0, en_m = 0;
  string       rx_tag = "R2", tx_tag = "R2";

  function automatic int rx_trig(input logic [1:0] s);
    case (s) 0: return 1; 1: return 8; 2: return 16; default: return 28; endcase
  endfunction
  function automatic int tx_trig(input logic [1:0] s);
    case (s) 0: return 16; 1: return 8; 2: return 4; default: return 1; endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit chg = (en_m != fifo_en_i);
    int cap = fifo_en_i ? 32 : 1;
    bit pop_ok, push_ok;
    rx_tag = "R2"; tx_tag = "R2";
    if (rx_clr_i || chg) begin
      rxq.delete(); ovr = 0; rx_tag = "R5";
    end else begin
      pop_ok  = rx_pop_i && rxq.size() > 0;
      push_ok = rx_push_i && (rxq.size() < cap || pop_ok);
      if (rx_push_i && !push_ok) ovr = 1;
      if (pop_ok && push_ok) rx_tag = "R11";
      if (pop_ok) rx_last = rxq.pop_front();
      if (push_ok) rxq.push_back({rx_err_i, rx_data_i});
    end
    if (tx_clr_i || chg) begin
      txq.delete(); tx_tag = "R5";
    end else begin
      pop_ok  = tx_pop_i && txq.size() > 0;
      push_ok = tx_push_i && (txq.size() < cap || pop_ok);
      if (pop_ok && push_ok) tx_tag = "R11";
      if (pop_ok) tx_last = txq.pop_front();
      if (push_ok) txq.push_back(tx_data_i);
    end
    en_m = fifo_en_i;
  endtask

  task automatic compare();
    int rc = rxq.size(), tc = txq.size();
    bit blk = fifo_en_i && dma_mode_i;
    bit rxreq = blk ? (rc >= rx_trig(rx_trig_sel_i)) : (rc != 0);
    bit txreq = blk ? (tc < tx_trig(tx_trig_sel_i)) : (tc == 0);
    logic [2:0] herr = (rc > 0) ? rxq[0][10:8] : 3'b000;
    bit anyerr = 0;
    foreach (rxq[k]) if (rxq[k][10:8] != 0) anyerr = 1;
    chk(rx_tag, rx_level_o, rc);
    chk(tx_tag, tx_level_o, tc);
    chk("R4 rx data", rx_data_o, rx_last[7:0]);
    chk("R4 tx data", tx_data_o, tx_last);
    chk("R7 pop err", rx_pop_err_o, rx_last[10:8]);
    if (rc > 0) chk("R4 rx peek", rx_peek_o, rxq[0][7:0]);
    if (tc > 0) chk("R4 tx peek", tx_peek_o, txq[0]);
    chk("R6 lsr0", lsr_o[0], rc != 0);
    chk("R6 lsr5", lsr_o[5], tc == 0);
    chk("R6 lsr6", lsr_o[6], (tc == 0) && !tx_busy_i);
    chk("R3 overrun", lsr_o[1], ovr);
    chk("R7 head err", lsr_o[4:2], herr);
    chk("R7 err sum", lsr_o[7], anyerr);
    chk(blk ? "R9 rxrdy" : "R8 rxrdy", rxrdy_no, !rxreq);
    chk(blk ? "R9 txrdy" : "R8 txrdy", txrdy_no, !txreq);
    chk("R10 rx irq", rx_irq_o, irq_en_i[0] && rxreq);
    chk("R10 tx irq", tx_irq_o, irq_en_i[1] && txreq);
    chk("R10 ls irq", ls_irq_o, irq_en_i[2] && (ovr || herr != 0));
  endtask

  task automatic step();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic idle_in();
    rx_push_i = 0; rx_pop_i = 0; tx_push_i = 0; tx_pop_i = 0;
    rx_clr_i = 0; tx_clr_i = 0; rx_err_i = 0;
  endtask

  task automatic randomize_in(input int push_bias);
    rx_push_i = ($urandom % 100) < push_bias;
    rx_pop_i  = ($urandom % 100) < (80 - push_bias);
    tx_push_i = ($urandom % 100) < push_bias;
    tx_pop_i  = ($urandom % 100) < (80 - push_bias);
    rx_data_i = 8'($urandom);
    tx_data_i = 8'($urandom);
    rx_err_i  = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
    rx_clr_i  = ($urandom % 90) == 0;
    tx_clr_i  = ($urandom % 90) == 0;
    tx_busy_i = 1'($urandom);
    if (($urandom % 400) == 0) fifo_en_i = ~fifo_en_i;
    if (($urandom % 100) == 0) dma_mode_i = ~dma_mode_i;
    if (($urandom % 50) == 0) rx_trig_sel_i = 2'($urandom);
    if (($urandom % 50) == 0) tx_trig_sel_i = 2'($urandom);
    if (($urandom % 60) == 0) irq_en_i = 3'($urandom);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd1337);
    if (seed == 0) seed = 1;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 lsr", lsr_o, 8'h60);
    chk("R1 txrdy", txrdy_no, 0);
    chk("R1 rxrdy", rxrdy_no, 1);
    chk("R1 irq", {tx_irq_o, rx_irq_o, ls_irq_o}, 0);
    chk("R1 levels", {tx_level_o, rx_level_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    compare();

    // block mode, receive fill past 28 trigger to overrun
    fifo_en_i = 1; dma_mode_i = 1; rx_trig_sel_i = 3; irq_en_i = 3'b111;
    step();
    for (int i = 0; i < 34; i++) begin
      idle_in(); rx_push_i = 1; rx_data_i = 8'(i + 8'h40);
      rx_err_i = (i == 5) ? 3'b010 : 3'b000;
      step();
    end
    // R11: push and pop together on a full queue
    idle_in(); rx_push_i = 1; rx_pop_i = 1; rx_data_i = 8'hA5; step();
    // drain and overdrain (R4 empty pop)
    for (int i = 0; i < 36; i++) begin
      idle_in(); rx_pop_i = 1; step();
    end
    // R3 cleared by R5 strobe, clear beats push
    idle_in(); rx_clr_i = 1; rx_push_i = 1; step();
    // transmit fill, sweep triggers
    for (int i = 0; i < 33; i++) begin
      idle_in(); tx_push_i = 1; tx_data_i = 8'(i * 3); tx_trig_sel_i = 2'(i % 4); step();
    end
    for (int i = 0; i < 33; i++) begin
      idle_in(); tx_pop_i = 1; tx_trig_sel_i = 2'(i % 4); step();
    end
    // single holding byte mode
    fifo_en_i = 0; idle_in(); step();
    for (int i = 0; i < 3; i++) begin
      idle_in(); rx_push_i = 1; tx_push_i = 1; rx_data_i = 8'(i + 1); tx_data_i = 8'(i + 9); step();
    end
    idle_in(); rx_pop_i = 1; tx_pop_i = 1; rx_push_i = 1; rx_data_i = 8'h77; step();
    idle_in(); rx_clr_i = 1; step();

    for (int blk = 0; blk < 10; blk++) begin
      int bias = (blk % 2) ? 60 : 30;
      for (int i = 0; i < 500; i++) begin
        randomize_in(bias);
        step();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule